// File: doc/BRIEF.md
# SDRAM Auto-Precharge Bank Guard

This block watches the command pins that a memory controller drives toward a multi-bank SDRAM. When it sees a write that asks for automatic precharge, it starts a countdown for the addressed bank. The countdown covers the rest of the write burst, the write recovery time and the precharge time. Until that countdown ends, the bank is reported as not ready, and any real command sent to it is flagged as a timing violation.

Burst length comes from a small configuration code. Write recovery and precharge times are static clock-count inputs, and each must be at least 1. A full-page burst never precharges on its own, so a write to such a burst leaves the bank free at once. Each bank keeps its own counter. Commands that act on every bank are checked against all of the counters.

Top module: `apre_bank_guard`

## Requirements
- R1: A command with ras_n_i=1, cas_n_i=0, we_n_i=0 and a10_i=1 is a write with auto-precharge. It makes bank_ready_o[ba_i] low in the cycle after the clock edge that sampled it.
- R2: bl_code_i values 0, 1, 2 and 3 select burst lengths 1, 2, 4 and 8. Let the write be sampled at edge e0 and let L = (BL-1)+t_wr_i+t_rp_i. The bank stays not ready until edge e(L-1) and is ready after it. A command to that bank sampled at edge ek is a violation exactly when k < L.
- R3: violation_o is high for one cycle, after the edge that sampled a non-NOP command aimed at a locked bank. It is low in every other cycle.
- R4: A NOP (ras_n_i, cas_n_i, we_n_i all 1) never raises violation_o.
- R5: When bl_code_i is 7 (full page), a write with a10_i=1 starts no lockout. The bank stays ready.
- R6: A write with a10_i=0 starts no lockout.
- R7: Banks are independent. A lockout on one bank neither flags nor delays commands to another bank.
- R8: Refresh (0,0,1), mode register set (0,0,0) and precharge (0,1,0) with a10_i=1 are aimed at every bank. Precharge with a10_i=0 is aimed at ba_i only.
- R9: A write with auto-precharge to a bank that is still locked is flagged and does not restart that bank's window.
- R10: After reset (rst_ni low), every bank is ready and violation_o is low. This holds even if a lockout was in progress.
- R11: With the minimum setting (BL 1, t_wr_i=1, t_rp_i=1), the window is 2 cycles. A command at e1 is flagged and a command at e2 is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_n_i | input | 1 | Row strobe command pin |
| cas_n_i | input | 1 | Column strobe command pin |
| we_n_i | input | 1 | Write enable command pin |
| a10_i | input | 1 | Address bit 10 (auto-precharge / all-bank flag) |
| ba_i | input | BA_W | Bank address |
| bl_code_i | input | 3 | Burst length code (0..3 = 1,2,4,8; 7 = full page) |
| t_wr_i | input | TW_W | Write recovery time in clocks (at least 1) |
| t_rp_i | input | TW_W | Precharge time in clocks (at least 1) |
| bank_ready_o | output | 2**BA_W | Per-bank ready flag |
| violation_o | output | 1 | Early-command flag, one cycle per offending command |

## Verification
The assertions check four properties on every cycle. A NOP or an idle bank set never produces a flag. A loaded counter falls by exactly one per clock and is never reloaded while it runs. Plain writes and full-page writes leave an idle bank ready. Only the bench scenarios can show the exact length of the window for a given burst code and set of timings. They also show the precise edge where a command changes from flagged to accepted, that all-bank commands see a lockout on another bank, and that reset cuts off a running window.

// File: rtl/apre_pkg.sv
package apre_pkg;
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  localparam logic [2:0] BL_FULL_PAGE = 3'b111;
endpackage

// File: rtl/apre_cmd_decode.sv
module apre_cmd_decode
  import apre_pkg::*;
#(
  parameter int BA_W = 1,
  localparam int NB = 1 << BA_W
) (
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic            a10_i,
  input  logic [BA_W-1:0] ba_i,
  output logic            nop_o,
  output logic            wr_o,
  output logic            wra_o,
  output logic [NB-1:0]   target_o
);
  cmd_e cmd;
  logic all_bank;

  assign cmd      = cmd_e'({ras_n_i, cas_n_i, we_n_i});
  assign nop_o    = (cmd == CMD_NOP);
  assign wr_o     = (cmd == CMD_WR);
  assign wra_o    = wr_o && a10_i;
  assign all_bank = (cmd == CMD_REF) || (cmd == CMD_MRS) || ((cmd == CMD_PRE) && a10_i);

  for (genvar b = 0; b < NB; b++) begin : g_tgt
    assign target_o[b] = !nop_o && (all_bank || (ba_i == BA_W'(b)));
  end
endmodule

// File: rtl/apre_bank_timer.sv
module apre_bank_timer #(
  parameter int TIME_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TIME_W-1:0] load_val_i,
  output logic              busy_o
);
  logic [TIME_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_load_locks_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> busy_o);

  assert_no_reload_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);

  assert_count_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/apre_bank_guard.sv
module apre_bank_guard
  import apre_pkg::*;
#(
  parameter int BA_W = 1,
  parameter int TW_W = 4,
  localparam int NB = 1 << BA_W,
  localparam int TIME_W = TW_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic            a10_i,
  input  logic [BA_W-1:0] ba_i,
  input  logic [2:0]      bl_code_i,
  input  logic [TW_W-1:0] t_wr_i,
  input  logic [TW_W-1:0] t_rp_i,
  output logic [NB-1:0]   bank_ready_o,
  output logic            violation_o
);
  logic              nop_c, wr_c, wra_c;
  logic [NB-1:0]     target_c, busy, hit;
  logic              full_page;
  logic [TIME_W-1:0] burst_len, load_val;
  logic              viol_q;

  apre_cmd_decode #(.BA_W(BA_W)) u_dec (
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .a10_i   (a10_i),
    .ba_i    (ba_i),
    .nop_o   (nop_c),
    .wr_o    (wr_c),
    .wra_o   (wra_c),
    .target_o(target_c)
  );

  assign full_page = (bl_code_i == BL_FULL_PAGE);
  assign burst_len = TIME_W'(1) << bl_code_i[1:0];
  // counter holds window minus one: ready drops for L-1 edges, command at e_L accepted
  assign load_val  = burst_len + TIME_W'(t_wr_i) + TIME_W'(t_rp_i) - TIME_W'(2);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic load;
    assign load = wra_c && !full_page && (ba_i == BA_W'(b)) && !busy[b];

    apre_bank_timer #(.TIME_W(TIME_W)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (load),
      .load_val_i(load_val),
      .busy_o    (busy[b])
    );

    assign hit[b]          = target_c[b] && busy[b];
    assign bank_ready_o[b] = !busy[b];

    assert_no_lock_on_plain_or_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_c && (!a10_i || full_page) && (ba_i == BA_W'(b)) && !busy[b]) |=> bank_ready_o[b]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) viol_q <= 1'b0;
    else         viol_q <= |hit;
  end

  assign violation_o = viol_q;

  assert_nop_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nop_c |=> !violation_o);

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&bank_ready_o) |=> !violation_o);
endmodule

// File: tb/tb_apre_bank_guard.sv
module tb_apre_bank_guard;
  localparam int BA_W = 1;
  localparam int TW_W = 4;
  localparam int NB = 1 << BA_W;

  localparam logic [2:0] C_MRS = 3'b000, C_REF = 3'b001, C_PRE = 3'b010, C_ACT = 3'b011,
                         C_WR  = 3'b100, C_RD  = 3'b101, C_NOP = 3'b111;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      cmd = C_NOP;
  logic            a10 = 1'b0;
  logic [BA_W-1:0] ba = '0;
  logic [2:0]      bl_code = 3'd0;
  logic [TW_W-1:0] t_wr = 4'd1, t_rp = 4'd1;
  logic [NB-1:0]   ready;
  logic            viol;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  apre_bank_guard #(.BA_W(BA_W), .TW_W(TW_W)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ras_n_i(cmd[2]), .cas_n_i(cmd[1]), .we_n_i(cmd[0]),
    .a10_i(a10), .ba_i(ba), .bl_code_i(bl_code),
    .t_wr_i(t_wr), .t_rp_i(t_rp),
    .bank_ready_o(ready), .violation_o(viol)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one command, return at the negedge after the sampling edge
  task automatic issue(input logic [2:0] c, input logic a, input logic [BA_W-1:0] b);
    cmd = c; a10 = a; ba = b;
    @(posedge clk); @(negedge clk);
    cmd = C_NOP; a10 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) issue(C_NOP, 1'b0, '0);
  endtask

  task automatic config_set(input logic [2:0] code, input int wr, input int rp);
    bl_code = code; t_wr = TW_W'(wr); t_rp = TW_W'(rp);
  endtask

  function automatic int window(input logic [2:0] code, input int wr, input int rp);
    return ((1 << code[1:0]) - 1) + wr + rp;
  endfunction

  task automatic t_reset;
    chk("R10 ready after reset", int'(ready), (1 << NB) - 1);
    chk("R10 violation after reset", int'(viol), 0);
  endtask

  // full window: ready timing and first legal edge
  task automatic t_window(input logic [2:0] code, input int wr, input int rp, input logic [BA_W-1:0] b);
    int len = window(code, wr, rp);
    config_set(code, wr, rp);
    issue(C_WR, 1'b1, b);
    chk("R1 ready low after write-autoprecharge", int'(ready[b]), 0);
    for (int k = 1; k < len; k++) begin
      issue(C_NOP, 1'b0, b);
      chk("R4 nop not flagged", int'(viol), 0);
      chk("R2 ready timing", int'(ready[b]), (k >= len - 1) ? 1 : 0);
    end
    issue(C_ACT, 1'b0, b);
    chk("R2 activate at window end accepted", int'(viol), 0);
    idle(1);
  endtask

  // command one edge too early
  task automatic t_early(input logic [2:0] code, input int wr, input int rp);
    int len = window(code, wr, rp);
    config_set(code, wr, rp);
    issue(C_WR, 1'b1, 1'b0);
    idle(len - 2);
    issue(C_ACT, 1'b0, 1'b0);
    chk("R2 activate one cycle early flagged", int'(viol), 1);
    issue(C_NOP, 1'b0, 1'b0);
    chk("R3 violation lasts one cycle", int'(viol), 0);
    idle(2);
  endtask

  task automatic t_min;
    config_set(3'd0, 1, 1);
    issue(C_WR, 1'b1, 1'b0);
    issue(C_ACT, 1'b0, 1'b0);
    chk("R11 minimum window e1 flagged", int'(viol), 1);
    issue(C_ACT, 1'b0, 1'b0);
    chk("R11 minimum window e2 accepted", int'(viol), 0);
    idle(1);
  endtask

  task automatic t_full_page;
    config_set(3'd7, 3, 3);
    issue(C_WR, 1'b1, 1'b0);
    chk("R5 full page keeps bank ready", int'(ready[0]), 1);
    issue(C_RD, 1'b0, 1'b0);
    chk("R5 full page no lockout", int'(viol), 0);
    idle(1);
  endtask

  task automatic t_plain_write;
    config_set(3'd2, 2, 2);
    issue(C_WR, 1'b0, 1'b1);
    chk("R6 plain write keeps bank ready", int'(ready[1]), 1);
    issue(C_ACT, 1'b0, 1'b1);
    chk("R6 plain write no lockout", int'(viol), 0);
    idle(1);
  endtask

  task automatic t_independent;
    config_set(3'd1, 2, 2);
    issue(C_WR, 1'b1, 1'b1);
    issue(C_ACT, 1'b0, 1'b0);
    chk("R7 other bank not flagged", int'(viol), 0);
    chk("R7 other bank ready", int'(ready[0]), 1);
    chk("R7 locked bank not ready", int'(ready[1]), 0);
    issue(C_RD, 1'b0, 1'b1);
    chk("R7 locked bank flagged", int'(viol), 1);
    idle(window(3'd1, 2, 2));
  endtask

  task automatic t_all_bank;
    config_set(3'd3, 4, 4);
    issue(C_WR, 1'b1, 1'b1);
    issue(C_REF, 1'b0, 1'b0);
    chk("R8 refresh sees other bank lock", int'(viol), 1);
    issue(C_PRE, 1'b0, 1'b0);
    chk("R8 single-bank precharge to free bank", int'(viol), 0);
    issue(C_PRE, 1'b1, 1'b0);
    chk("R8 precharge-all flagged", int'(viol), 1);
    issue(C_MRS, 1'b0, 1'b0);
    chk("R8 mode set flagged", int'(viol), 1);
    idle(window(3'd3, 4, 4));
    issue(C_REF, 1'b0, 1'b0);
    chk("R8 refresh after window accepted", int'(viol), 0);
  endtask

  task automatic t_no_restart;
    config_set(3'd0, 1, 3); // L = 4
    issue(C_WR, 1'b1, 1'b0);          // e0
    issue(C_NOP, 1'b0, 1'b0);         // e1
    issue(C_WR, 1'b1, 1'b0);          // e2
    chk("R9 rewrite to locked bank flagged", int'(viol), 1);
    issue(C_NOP, 1'b0, 1'b0);         // e3
    chk("R9 ready back at original time", int'(ready[0]), 1);
    idle(1);
  endtask

  task automatic t_reset_mid;
    config_set(3'd3, 5, 5);
    issue(C_WR, 1'b1, 1'b0);
    rst_n = 1'b0;
    #1;
    chk("R10 reset clears lockout", int'(ready[0]), 1);
    @(negedge clk);
    rst_n = 1'b1;
    issue(C_ACT, 1'b0, 1'b0);
    chk("R10 command after reset accepted", int'(viol), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window(3'd2, 2, 2, 1'b0);
    t_window(3'd3, 15, 15, 1'b1);
    t_early(3'd1, 3, 2);
    t_min();
    t_full_page();
    t_plain_write();
    t_independent();
    t_all_bank();
    t_no_restart();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule